// File: doc/BRIEF.md
# Addressed Serial DAC Register Bank

This block is the digital front end of an eight-channel, 8-bit voltage DAC. A host drives an active-low chip select, a serial clock and a serial data line. While chip select is low, each rising edge of the serial clock shifts one data bit into an 11-bit window, most significant bit first. When chip select returns high, the 11 bits in the window are read as a 3-bit channel number followed by an 8-bit code, and that code is written into the selected output register.

Hosts that can only send whole bytes pad each write to 16 bits. Only the newest 11 bits count, so a padded write has the same effect as an exact one. All serial inputs are sampled by a faster system clock through two-stage synchronizers, and their edges are found on the synchronized copies. An asynchronous reset puts every channel at the midscale code. A shutdown input is passed to a flag output and has no effect on the stored codes.

Top module: `serial_dac_bank`

## Requirements
- R1: While rst_n is low, all eight channel codes read 0x80, asynchronously. They keep that value until a valid write arrives.
- R2: A frame holds 11 bits, sent MSB first. Bits 10..8 give the channel number and bits 7..0 give the code. Channel n is carried on codes_o[8n+7:8n].
- R3: A bit is taken only on a rising edge of sclk while cs_n is low. Each falling edge of cs_n starts a new frame and discards the bits of earlier frames.
- R4: When more than 11 bits arrive in one cs_n-low window, only the last 11 are used. A 16-bit frame writes the same channel and code as an 11-bit frame made of its low 11 bits.
- R5: When fewer than 11 bits arrive before cs_n rises, no channel changes.
- R6: A write changes only the addressed channel. The other seven keep their codes.
- R7: shdn_o follows shdn after two rising clk edges, and a change on shdn leaves every code unchanged.
- R8: A write becomes visible on codes_o right after the fourth rising clk edge that follows cs_n going high, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host; must be high when cs_n rises |
| sdi | input | 1 | Serial data, MSB first |
| shdn | input | 1 | Shutdown request |
| codes_o | output | 64 | Eight 8-bit channel codes; channel n at bits 8n+7:8n |
| shdn_o | output | 1 | Synchronized shutdown flag |

## Verification
The hardest case to produce from the ports is the bit count carrying over from one chip-select window into the next. The bench therefore sends a 7-bit window and then a 4-bit window, which would add up to a complete frame if the count were not cleared. No channel may change. Sclk pulses are also sent while cs_n is high, to show they are ignored. A reference model tracks every channel and is compared with codes_o on every clock. This fixes the exact cycle a write lands in, and it also covers padded 16-bit frames, short frames and a reset applied in the middle of the run.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    parameter int ADDR_W = 3;
    parameter int CODE_W = 8;
    localparam int WORD_W = ADDR_W + CODE_W;
    localparam int NCH    = 1 << ADDR_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CODE_W-1:0] MIDCODE = CODE_W'(1 << (CODE_W - 1));

    typedef struct packed {
        logic              sclk_p;
        logic              csn_p;
        logic [WORD_W-1:0] win;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] code;
    } shift_st_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CODE_W-1:0] code_o
);
    shift_st_t st_d, st_q;
    logic sclk_rise, cs_fall, cs_rise;

    always_comb begin
        sclk_rise = sclk_s & ~st_q.sclk_p;
        cs_fall   = ~csn_s & st_q.csn_p;
        cs_rise   = csn_s & ~st_q.csn_p;
        st_d        = st_q;
        st_d.wr     = 1'b0;
        st_d.sclk_p = sclk_s;
        st_d.csn_p  = csn_s;
        if (cs_fall) begin
            st_d.cnt = '0;
        end else if (!csn_s && sclk_rise) begin
            st_d.win = {st_q.win[WORD_W-2:0], sdi_s};
            if (st_q.cnt != CNT_W'(WORD_W)) st_d.cnt = st_q.cnt + 1'b1;
        end
        if (cs_rise && st_q.cnt == CNT_W'(WORD_W)) begin
            st_d.wr   = 1'b1;
            st_d.addr = st_q.win[WORD_W-1 -: ADDR_W];
            st_d.code = st_q.win[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.sclk_p <= 1'b1;
            st_q.csn_p  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_o   = st_q.wr;
    assign addr_o = st_q.addr;
    assign code_o = st_q.code;

    p_short_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && st_q.cnt < CNT_W'(WORD_W)) |=> !wr_o);
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(WORD_W));
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);
    p_fall_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> st_q.cnt == '0);
endmodule

// File: rtl/sdac_regbank.sv
module sdac_regbank
    import sdac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [CODE_W-1:0]     code_i,
    output logic [NCH*CODE_W-1:0] codes_o
);
    logic [NCH-1:0][CODE_W-1:0] codes_d, codes_q;

    always_comb begin
        codes_d = codes_q;
        if (wr_i) codes_d[addr_i] = code_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) codes_q[i] <= MIDCODE;
        end else begin
            codes_q <= codes_d;
        end
    end

    assign codes_o = codes_q;

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_i && addr_i == ADDR_W'(g)) |=> $stable(codes_q[g]));
        p_reset_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> codes_q[g] == MIDCODE);
    end
endmodule

// File: rtl/serial_dac_bank.sv
module serial_dac_bank
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  sdi,
    input  logic                  shdn,
    output logic [NCH*CODE_W-1:0] codes_o,
    output logic                  shdn_o
);
    localparam int NSYNC = 4;
    logic [NSYNC-1:0] raw, synced;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;

    assign raw = {shdn, sdi, cs_n, sclk};

    sdac_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw), .dout(synced)
    );

    sdac_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_s(synced[0]), .csn_s(synced[1]),
        .sdi_s(synced[2]), .wr_o(wr), .addr_o(addr), .code_o(code)
    );

    sdac_regbank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .addr_i(addr), .code_i(code),
        .codes_o(codes_o)
    );

    assign shdn_o = synced[3];

    p_shdn_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(codes_o));
endmodule

// File: tb/sim_serial_dac_bank.sv
module sim_serial_dac_bank;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0, shdn = 1'b0;
    logic [63:0] codes_o;
    logic shdn_o;
    int checks = 0;
    int errors = 0;
    int model[8];
    bit done = 1'b0;

    serial_dac_bank u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .shdn(shdn), .codes_o(codes_o), .shdn_o(shdn_o));

    always #4 clk = ~clk;

    initial for (int i = 0; i < 8; i++) model[i] = 8'h80;

    // Per-clock comparison against the reference model (R2, R8)
    always @(negedge clk) begin
        #1;
        if (!done) begin
            checks++;
            for (int ch = 0; ch < 8; ch++) begin
                if (int'(codes_o[ch*8 +: 8]) != model[ch]) begin
                    errors++;
                    $display("FAIL R8 per-clock ch%0d actual %02h expected %02h at %0t",
                             ch, codes_o[ch*8 +: 8], model[ch], $time);
                    break;
                end
            end
        end
    end

    task automatic chk(input int ch, input int exp, input string req);
        checks++;
        if (int'(codes_o[ch*8 +: 8]) != exp) begin
            errors++;
            $display("FAIL %s ch%0d actual %02h expected %02h", req, ch,
                     codes_o[ch*8 +: 8], exp);
        end
    endtask

    task automatic half(); repeat (8) @(negedge clk); endtask

    task automatic send(input int nbits, input logic [15:0] w);
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            sclk = 1'b0; sdi = w[i]; half();
            sclk = 1'b1; half();
        end
        cs_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        if (nbits >= 11) model[w[10:8]] = w[7:0];
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int ch = 0; ch < 8; ch++) chk(ch, 8'h80, "R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int ch = 0; ch < 8; ch++) chk(ch, 8'h80, "R1");
        // R2: exact 11-bit frames, several patterns
        send(11, {5'b0, 3'd2, 8'h5A});
        chk(2, 8'h5A, "R2");
        chk(3, 8'h80, "R6");
        send(11, {5'b0, 3'd7, 8'hFF});
        chk(7, 8'hFF, "R2");
        send(11, {5'b0, 3'd0, 8'h00});
        chk(0, 8'h00, "R2");
        chk(2, 8'h5A, "R6");
        // R4: padded 16-bit frame, junk in top 5 bits
        send(16, {5'b10111, 3'd5, 8'hC3});
        chk(5, 8'hC3, "R4");
        send(13, {3'b0, 2'b11, 3'd1, 8'h3C});
        chk(1, 8'h3C, "R4");
        // R5: short frame ignored
        send(10, {6'b0, 2'd3, 8'h11});
        chk(3, 8'h80, "R5");
        chk(6, 8'h80, "R5");
        // R3: sclk toggling with cs high is ignored, count restarts per window
        for (int k = 0; k < 8; k++) begin
            sclk = 1'b0; sdi = 1'b1; half(); sclk = 1'b1; half();
        end
        send(7, 16'h0046);
        send(4, 16'h000F);
        for (int ch = 0; ch < 8; ch++) chk(ch, model[ch], "R3");
        // R7: shutdown passes through, codes kept
        @(negedge clk); shdn = 1'b1;
        @(negedge clk);
        checks++;
        if (shdn_o !== 1'b0) begin errors++; $display("FAIL R7 early shdn_o actual %b expected 0", shdn_o); end
        @(negedge clk);
        checks++;
        if (shdn_o !== 1'b1) begin errors++; $display("FAIL R7 shdn_o actual %b expected 1", shdn_o); end
        repeat (5) @(negedge clk);
        chk(5, 8'hC3, "R7");
        send(11, {5'b0, 3'd4, 8'h99});
        chk(4, 8'h99, "R7");
        shdn = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (shdn_o !== 1'b0) begin errors++; $display("FAIL R7 shdn_o actual %b expected 0", shdn_o); end
        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 8'h80;
        #2;
        for (int ch = 0; ch < 8; ch++) chk(ch, 8'h80, "R1");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        send(16, {5'b0, 3'd6, 8'h01});
        chk(6, 8'h01, "R2");
        chk(4, 8'h80, "R1");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule